// File: doc/BRIEF.md
# Packed Register-Write Command Decoder

This block sits between a command-buffer word stream and an internal register bus. Words arrive in fixed groups of five. The first word of a group is a header that carries four one-byte register indices. The four words after it are the values to write. For each value the block turns the matching index into a full byte address and presents one write on a valid/ready write port. The writes leave in stream order and there is no added latency: a data word goes straight onto the write port, and the input is held back for as long as the write port stalls.

The top bit of an index selects one of two 512-byte register windows. The other seven bits select a 32-bit register inside that window. One fixed address acts as a padding target, so that unused slots in a group can be filled. A write to it is consumed and never reaches the bus. The block drives a busy flag while a group is open. It also combines that flag with an external engine status word into a single idle indication.

Top module: `regwr_unpacker`

## Requirements
- R1: A group is one header word followed by exactly four data words. The word accepted after the fourth data word is treated as the header of the next group.
- R2: Header bits 7:0 give the index for data word 1, bits 15:8 for data word 2, bits 23:16 for data word 3 and bits 31:24 for data word 4.
- R3: An index with bit 7 = 0 targets byte address 0x1C00 + index[6:0]*4.
- R4: An index with bit 7 = 1 targets byte address 0x2C00 + index[6:0]*4.
- R5: Every issued write address lies in 0x1C00..0x1DFF or in 0x2C00..0x2DFF.
- R6: Each data word that is not dropped produces exactly one write, with wrData equal to the data word. The writes follow stream order. A header word never produces a write.
- R7: While wrValid is high and wrReady is low, inReady is low.
- R8: A data word whose target is 0x1C54 (bank-0 index 0x15) is accepted with no write issued. The same index in bank 1 (0x2C54) is written normally.
- R9: busy rises in the cycle after a header is accepted. It stays high until the fourth data word of that group is accepted, and falls in the cycle after that.
- R10: engineIdle is high exactly when busy is low and status bits {17,16,0} equal {1,0,0}. All other status bits are ignored.
- R11: Synchronous reset clears busy and returns the word position to the header slot. This holds even in the middle of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inWord | input | 32 | Command stream word |
| inValid | input | 1 | inWord is valid |
| inReady | output | 1 | Block accepts inWord this cycle |
| wrAddr | output | 14 | Register byte address of the write |
| wrData | output | 32 | Register write value |
| wrValid | output | 1 | A write is offered |
| wrReady | input | 1 | Register bus accepts the write |
| statusWord | input | 32 | Engine status word |
| busy | output | 1 | A group is in progress |
| engineIdle | output | 1 | Stream drained and engine status reports idle |

## Verification
The bench sends groups of several kinds:
- All indices in bank 0, and all indices in bank 1, which separates the two base addresses.
- Four distinct indices, which exposes any byte-order swap.
- Indices 0x00, 0x7F, 0x80 and 0xFF, which hit the window edges.
- Headers that mix the padding index with its bank-1 twin, so that dropping by raw index can be told apart from dropping by full address.

Some runs apply random write-port stalls, which show whether back-pressure loses or repeats words. A reset in the middle of a group shows whether the word position is realigned. The status patterns set and clear each of the three relevant bits and also fill the unrelated bits, to confirm that only those three bits count.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic takeIdx;   // header word accepted this cycle
    logic takeData;  // data word accepted this cycle
  } ctlStb_t;
endpackage

// File: rtl/regwr_ctl.sv
module regwr_ctl
  import regwr_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int POS_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             wrReady,
  input  logic             dropNow,
  output logic             inReady,
  output logic             wrValid,
  output logic             busy,
  output logic [POS_W-1:0] slotPos,
  output ctlStb_t          stb
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOTS);

  always_comb begin
    stb     = '0;
    inReady = 1'b0;
    wrValid = 1'b0;
    if (slotPos == '0) begin
      inReady     = 1'b1;
      stb.takeIdx = inValid;
    end else begin
      wrValid      = inValid && !dropNow;
      inReady      = dropNow || wrReady;
      stb.takeData = inValid && (dropNow || wrReady);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotPos <= '0;
      busy    <= 1'b0;
    end else if (stb.takeIdx) begin
      slotPos <= POS_W'(1);
      busy    <= 1'b1;
    end else if (stb.takeData) begin
      if (slotPos == LAST_POS) begin
        slotPos <= '0;
        busy    <= 1'b0;
      end else begin
        slotPos <= slotPos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/regwr_dp.sv
module regwr_dp
  import regwr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 14,
  parameter int SLOTS      = 4,
  parameter int IDX_W      = 8,
  parameter int BANK0_BASE = 'h1C00,
  parameter int BANK1_BASE = 'h2C00,
  parameter int PAD_ADDR   = 'h1C54,
  parameter int STAT_W     = 32,
  parameter int TRAP_BIT   = 0,
  parameter int ENG_BIT    = 16,
  parameter int DMAEND_BIT = 17,
  localparam int POS_W = $clog2(SLOTS + 1),
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStb_t           stb,
  input  logic [POS_W-1:0]  slotPos,
  input  logic [DATA_W-1:0] inWord,
  input  logic [STAT_W-1:0] statusWord,
  input  logic              busy,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              dropNow,
  output logic              engineIdle
);
  localparam logic [STAT_W-1:0] IDLE_MASK =
    (STAT_W'(1) << TRAP_BIT) | (STAT_W'(1) << ENG_BIT) | (STAT_W'(1) << DMAEND_BIT);
  localparam logic [STAT_W-1:0] IDLE_VAL = STAT_W'(1) << DMAEND_BIT;

  logic [DATA_W-1:0] idxReg;
  logic [IDX_W-1:0]  idxByte [SLOTS];
  logic [SEL_W-1:0]  selPos;
  logic [IDX_W-1:0]  selIdx;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] offAddr;

  always_ff @(posedge clk) begin
    if (rst) idxReg <= '0;
    else if (stb.takeIdx) idxReg <= inWord;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_bytes
    assign idxByte[g] = idxReg[g*IDX_W +: IDX_W];
  end

  assign selPos   = SEL_W'(slotPos - 1'b1);
  assign selIdx   = idxByte[selPos];
  assign baseAddr = selIdx[IDX_W-1] ? ADDR_W'(BANK1_BASE) : ADDR_W'(BANK0_BASE);
  assign offAddr  = ADDR_W'({selIdx[IDX_W-2:0], 2'b00});
  assign wrAddr   = baseAddr + offAddr;
  assign wrData   = inWord;
  assign dropNow  = (slotPos != '0) && (wrAddr == ADDR_W'(PAD_ADDR));

  assign engineIdle = !busy && ((statusWord & IDLE_MASK) == IDLE_VAL);
endmodule

// File: rtl/regwr_unpacker.sv
module regwr_unpacker
  import regwr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 14,
  parameter int SLOTS      = 4,
  parameter int IDX_W      = 8,
  parameter int BANK0_BASE = 'h1C00,
  parameter int BANK1_BASE = 'h2C00,
  parameter int PAD_ADDR   = 'h1C54,
  parameter int STAT_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inWord,
  input  logic              inValid,
  output logic              inReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  input  logic              wrReady,
  input  logic [STAT_W-1:0] statusWord,
  output logic              busy,
  output logic              engineIdle
);
  localparam int POS_W = $clog2(SLOTS + 1);

  ctlStb_t          stb;
  logic [POS_W-1:0] slotPos;
  logic             dropNow;

  regwr_ctl #(.SLOTS(SLOTS)) u_ctl (
    .clk(clk), .rst(rst), .inValid(inValid), .wrReady(wrReady),
    .dropNow(dropNow), .inReady(inReady), .wrValid(wrValid),
    .busy(busy), .slotPos(slotPos), .stb(stb)
  );

  regwr_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS), .IDX_W(IDX_W),
    .BANK0_BASE(BANK0_BASE), .BANK1_BASE(BANK1_BASE),
    .PAD_ADDR(PAD_ADDR), .STAT_W(STAT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .slotPos(slotPos), .inWord(inWord),
    .statusWord(statusWord), .busy(busy), .wrAddr(wrAddr),
    .wrData(wrData), .dropNow(dropNow), .engineIdle(engineIdle)
  );
endmodule

// File: rtl/regwr_unpacker_chk.sv
module regwr_unpacker_chk #(
  parameter int ADDR_W     = 14,
  parameter int IDX_W      = 8,
  parameter int BANK0_BASE = 'h1C00,
  parameter int BANK1_BASE = 'h2C00,
  parameter int PAD_ADDR   = 'h1C54
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              wrValid,
  input logic              wrReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              busy,
  input logic              engineIdle
);
  localparam int WIN_BYTES = (1 << (IDX_W - 1)) * 4;
  localparam logic [ADDR_W-1:0] B0LO = ADDR_W'(BANK0_BASE);
  localparam logic [ADDR_W-1:0] B0HI = ADDR_W'(BANK0_BASE + WIN_BYTES - 1);
  localparam logic [ADDR_W-1:0] B1LO = ADDR_W'(BANK1_BASE);
  localparam logic [ADDR_W-1:0] B1HI = ADDR_W'(BANK1_BASE + WIN_BYTES - 1);

  assert_addr_window_R5: assert property (@(posedge clk) disable iff (rst)
    wrValid |-> ((wrAddr >= B0LO && wrAddr <= B0HI) || (wrAddr >= B1LO && wrAddr <= B1HI)));

  assert_write_in_group_R6: assert property (@(posedge clk) disable iff (rst)
    wrValid |-> busy);

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !wrReady) |-> !inReady);

  assert_pad_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    wrValid |-> (wrAddr != ADDR_W'(PAD_ADDR)));

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && inValid && inReady) |=> busy);

  assert_idle_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    engineIdle |-> !busy);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> !busy);
endmodule

bind regwr_unpacker regwr_unpacker_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK0_BASE(BANK0_BASE),
  .BANK1_BASE(BANK1_BASE), .PAD_ADDR(PAD_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
  .busy(busy), .engineIdle(engineIdle)
);

// File: tb/regwr_unpacker_test.sv
`timescale 1ns/1ps
module regwr_unpacker_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] inWord = '0;
  logic        inValid = 0;
  logic        inReady;
  logic [13:0] wrAddr;
  logic [31:0] wrData;
  logic        wrValid;
  logic        wrReady = 1;
  logic [31:0] statusWord = '0;
  logic        busy;
  logic        engineIdle;

  int checks = 0;
  int errors = 0;
  logic [45:0] expQ[$];
  logic stallOn = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  regwr_unpacker uut (
    .clk(clk), .rst(rst), .inWord(inWord), .inValid(inValid), .inReady(inReady),
    .wrAddr(wrAddr), .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .statusWord(statusWord), .busy(busy), .engineIdle(engineIdle)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] expAddr(input logic [7:0] idx);
    expAddr = (idx[7] ? 14'h2C00 : 14'h1C00) + {5'd0, idx[6:0], 2'b00};
  endfunction

  // write-port stall pattern
  initial forever begin
    @(posedge clk); #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wrReady = stallOn ? (lfsr[0] & lfsr[3]) | lfsr[5] : 1'b1;
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (!rst && wrValid && !wrReady)
      check(!inReady, "R7 inReady during stall", inReady, 0);
    if (!rst && wrValid && wrReady) begin
      if (expQ.size() == 0) begin
        check(0, "R6 unexpected write", {18'd0, wrAddr, wrData}, 0);
      end else begin
        logic [45:0] e;
        e = expQ.pop_front();
        check({wrAddr, wrData} == e, "R2/R3/R4/R6 write addr,data", {18'd0, wrAddr, wrData}, {18'd0, e});
      end
    end
  end

  task automatic sendWord(input logic [31:0] w);
    logic done;
    done = 0;
    inWord = w; inValid = 1;
    while (!done) begin
      @(negedge clk);
      done = inReady;
      @(posedge clk); #2;
    end
    inValid = 0;
  endtask

  task automatic sendBlock(input logic [31:0] hdr, input logic [31:0] d0, input logic [31:0] d1,
                           input logic [31:0] d2, input logic [31:0] d3);
    logic [31:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    for (int k = 0; k < 4; k++) begin
      logic [13:0] a;
      a = expAddr(hdr[k*8 +: 8]);
      if (a != 14'h1C54) expQ.push_back({a, d[k]});  // R8 drop model
    end
    sendWord(hdr);
    check(busy == 1'b1, "R9 busy after header", busy, 1);
    for (int k = 0; k < 4; k++) sendWord(d[k]);
    check(busy == 1'b0, "R9 busy cleared after fourth word", busy, 0);
  endtask

  task automatic drain(input string req);
    repeat (4) @(posedge clk);
    #2;
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(busy == 0, "R11 busy after reset", busy, 0);
    check(inReady == 1, "R11 header slot ready after reset", inReady, 1);
    check(wrValid == 0, "R6 no write at reset", wrValid, 0);
    @(posedge clk); #2;

    // R1 R2 R3: bank 0, distinct indices
    sendBlock(32'h0C_08_04_00, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    drain("R1 bank0 group drained");
    // R4: bank 1
    sendBlock(32'h83_82_81_80, 32'hA0A0A0A0, 32'hA1A1A1A1, 32'hA2A2A2A2, 32'hA3A3A3A3);
    drain("R4 bank1 group drained");
    // R2 byte order with mixed banks; R5 window edges
    sendBlock(32'hFF_00_7F_80, 32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'hCAFEF00D);
    drain("R5 edge group drained");
    // R8 pad vs bank-1 twin
    sendBlock(32'h00_15_95_15, 32'h5A5A0001, 32'h5A5A0002, 32'h5A5A0003, 32'h5A5A0004);
    drain("R8 pad group drained");
    // R8 all pads: no writes at all
    sendBlock(32'h15151515, 32'h1, 32'h2, 32'h3, 32'h4);
    drain("R8 all-pad group");

    // R7 under random stalls, back-to-back groups
    stallOn = 1;
    for (int g = 0; g < 6; g++)
      sendBlock({8'(g*17+3), 8'(g*5+130), 8'(g*9+1), 8'(g+200)},
                32'h1000 + g, 32'h2000 + g, 32'h3000 + g, 32'h4000 + g);
    stallOn = 0;
    drain("R7 stalled groups drained");

    // R10 engine idle decode
    statusWord = 32'h0002_0000; #1;
    check(engineIdle == 1, "R10 idle when only bit17", engineIdle, 1);
    statusWord = 32'h0003_0000; #1;
    check(engineIdle == 0, "R10 bit16 busy", engineIdle, 0);
    statusWord = 32'h0002_0001; #1;
    check(engineIdle == 0, "R10 bit0 pending", engineIdle, 0);
    statusWord = 32'h0000_0000; #1;
    check(engineIdle == 0, "R10 bit17 clear", engineIdle, 0);
    statusWord = 32'hFFFE_FFFE; #1;
    check(engineIdle == 1, "R10 other bits ignored", engineIdle, 1);
    statusWord = 32'h0002_0000;
    expQ.push_back({14'h1C04, 32'h77770000});
    sendWord(32'h00000001);
    @(negedge clk);
    check(engineIdle == 0, "R10 not idle while busy", engineIdle, 0);
    @(posedge clk); #2;

    // R11 mid-group reset
    sendWord(32'h77770000);
    rst = 1;
    repeat (2) @(posedge clk); #2;
    rst = 0;
    @(negedge clk);
    check(busy == 0, "R11 busy cleared mid-group", busy, 0);
    check(inReady == 1 && wrValid == 0, "R11 back at header slot", {inReady, wrValid}, 2'b10);
    @(posedge clk); #2;
    drain("R11 pre-reset write delivered");
    sendBlock(32'h90_10_85_05, 32'hB0, 32'hB1, 32'hB2, 32'hB3);
    drain("R1 R11 realigned group");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule